// File: doc/BRIEF.md
# Tagged-Arithmetic Integer Execute Unit

This block is the integer execute stage of a 32-bit pipeline. Each accepted operation takes a first operand and a second operand. The second operand is either a register value or a sign-extended 13-bit constant. The block produces a result, a destination write-enable and a trap request, and it holds the integer condition codes N, Z, V and C. Supported operations are add and subtract, each with or without the carry flag, and tagged add and subtract, which also have trapping forms. The logical set includes the inverted-second-operand forms. The block also performs three shifts and a load of the upper 22 bits.

Operations enter on a valid/ready port and leave on a valid/ready port through a single output stage. `in_ready` is high when the output stage is empty, or when its content is consumed in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds, and no new operation enters. The condition codes change on the clock edge that accepts an operation. A carry-using operation issued directly afterwards therefore sees the updated flags.

Top module: `alu_tag_exec`

## Requirements
- R1: With `in_use_imm`=0 the second operand is `in_b`. With `in_use_imm`=1 it is `in_imm` sign-extended to 32 bits.
- R2: Opcode encodings are ADD=0, ADDC=1, SUB=2, SUBC=3. `cc` packs bit3=N, bit2=Z, bit1=V, bit0=C. For arithmetic, N is result bit 31 and Z means the result is zero. V is signed overflow. C is the carry out for add and the unsigned borrow for subtract.
- R3: ADDC adds the current C flag as carry-in. SUBC subtracts the current C flag as a borrow.
- R4: Tagged ops are TADD=4 and TSUB=5. They set V on signed overflow, and also when bits 1:0 of either operand are nonzero.
- R5: The trapping forms are TADDT=6 and TSUBT=7. When their V would be set, `out_trap` is 1, `out_wr` is 0, and `cc` is left unchanged. Otherwise they act as TADD and TSUB.
- R6: The logical ops are AND=8, ANDN=9, OR=10, ORN=11, XOR=12 and XNOR=13. The N forms invert the second operand first. When flags are written, V and C are cleared.
- R7: SETHI=17 puts `in_hi` into result bits 31:10 and clears bits 9:0.
- R8: The shifts are SLL=14, SRL=15 and SRA=16. The distance is the low 5 bits of the second operand, and SRA replicates bit 31. Shifts and SETHI never change `cc`.
- R9: While `out_valid`=1 and `out_ready`=0, the outputs and `cc` hold and `in_ready` is 0.
- R10: Opcodes 0-3 and 8-13 update `cc` only when `in_setcc`=1. Opcodes 4-7 update it regardless of `in_setcc`, except in the trap case.
- R11: Opcodes 18-31 give result 0, `out_wr`=0 and `out_trap`=0, and leave `cc` unchanged.
- R12: After reset, `out_valid`=0, `in_ready`=1 and `cc`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted when high with in_valid |
| in_op | input | 5 | Opcode |
| in_setcc | input | 1 | Write condition codes (non-tagged ops) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Register second operand |
| in_imm | input | 13 | Immediate second operand |
| in_use_imm | input | 1 | Select immediate |
| in_hi | input | 22 | Constant for SETHI |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_result | output | 32 | Result value |
| out_wr | output | 1 | Destination write-enable |
| out_trap | output | 1 | Tag-overflow trap request |
| cc | output | 4 | Condition codes {N,Z,V,C} |

## Verification
The bench builds the unit with the default parameters: 32-bit data, a 13-bit immediate, a 22-bit high constant and a 2-bit tag. With these values the boundaries are easy to reach from the operand ports. Signed overflow occurs at 0x7FFFFFFF, carry out at 0xFFFFFFFF, and a shift distance of 37 wraps to 5. A single low operand bit turns on the tag-overflow path. The table runs the operations in a chain, so each carry-using and trapping case starts from flags that an earlier entry left behind.

// File: rtl/alu_tag_pkg.sv
package alu_tag_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBC  = 5'd3,
    OP_TADD  = 5'd4,
    OP_TSUB  = 5'd5,
    OP_TADDT = 5'd6,
    OP_TSUBT = 5'd7,
    OP_AND   = 5'd8,
    OP_ANDN  = 5'd9,
    OP_OR    = 5'd10,
    OP_ORN   = 5'd11,
    OP_XOR   = 5'd12,
    OP_XNOR  = 5'd13,
    OP_SLL   = 5'd14,
    OP_SRL   = 5'd15,
    OP_SRA   = 5'd16,
    OP_SETHI = 5'd17
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/alu_opsel.sv
module alu_opsel #(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input  logic [W-1:0]     b_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  output logic [W-1:0]     op2
);
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] imm_ext;
  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign op2     = use_imm ? imm_ext : b_reg;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W     = 32,
  parameter int TAG_W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_c,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         v_ovf,
  output logic         tag_nz
);
  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   full;

  assign b_eff = sub ? ~b : b;
  assign cin   = use_c ? (sub ? ~c_in : c_in) : sub;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = full[W-1:0];
  assign c_out = sub ? ~full[W] : full[W];
  assign v_ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  assign tag_nz = (|a[TAG_W-1:0]) | (|b[TAG_W-1:0]);
endmodule

// File: rtl/alu_logsh.sv
module alu_logsh
  import alu_tag_pkg::*;
#(
  parameter int W    = 32,
  parameter int HI_W = 22
) (
  input  op_e             op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [HI_W-1:0] hi,
  output logic [W-1:0]    res
);
  localparam int SH_W = $clog2(W);
  localparam int LO_W = W - HI_W;

  logic [SH_W-1:0] shamt;
  assign shamt = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      OP_AND:   res = a & b;
      OP_ANDN:  res = a & ~b;
      OP_OR:    res = a | b;
      OP_ORN:   res = a | ~b;
      OP_XOR:   res = a ^ b;
      OP_XNOR:  res = a ^ ~b;
      OP_SLL:   res = a << shamt;
      OP_SRL:   res = a >> shamt;
      OP_SRA:   res = $unsigned($signed(a) >>> shamt);
      OP_SETHI: res = {hi, {LO_W{1'b0}}};
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/alu_tag_exec.sv
module alu_tag_exec
  import alu_tag_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 13,
  parameter int HI_W  = 22,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [4:0]       in_op,
  input  logic             in_setcc,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [IMM_W-1:0] in_imm,
  input  logic             in_use_imm,
  input  logic [HI_W-1:0]  in_hi,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result,
  output logic             out_wr,
  output logic             out_trap,
  output logic [3:0]       cc
);
  op_e          op;
  cc_t          cc_q, cc_n;
  logic [W-1:0] op2, sum, lres, res_c;
  logic         c_out, v_ovf, tag_nz;
  logic         is_arith, is_tag, is_tv, is_logic, is_known;
  logic         is_sub, use_c, v_fin, trap_c, wr_c, cc_upd, acc;

  assign op = op_e'(in_op);

  alu_opsel #(.W(W), .IMM_W(IMM_W)) u_opsel (
    .b_reg(in_b), .imm(in_imm), .use_imm(in_use_imm), .op2(op2)
  );

  assign is_arith = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBC);
  assign is_tag   = (op == OP_TADD) || (op == OP_TSUB) || (op == OP_TADDT) || (op == OP_TSUBT);
  assign is_tv    = (op == OP_TADDT) || (op == OP_TSUBT);
  assign is_logic = (in_op >= 5'd8) && (in_op <= 5'd13);
  assign is_known = in_op <= 5'd17;
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_TSUB) || (op == OP_TSUBT);
  assign use_c    = (op == OP_ADDC) || (op == OP_SUBC);

  alu_addsub #(.W(W), .TAG_W(TAG_W)) u_addsub (
    .a(in_a), .b(op2), .sub(is_sub), .use_c(use_c), .c_in(cc_q.c),
    .sum(sum), .c_out(c_out), .v_ovf(v_ovf), .tag_nz(tag_nz)
  );

  alu_logsh #(.W(W), .HI_W(HI_W)) u_logsh (
    .op(op), .a(in_a), .b(op2), .hi(in_hi), .res(lres)
  );

  always_comb begin
    v_fin  = v_ovf | (is_tag & tag_nz);
    trap_c = is_tv & v_fin;
    wr_c   = is_known & ~trap_c;
    if (is_arith || is_tag) res_c = sum;
    else if (is_known)      res_c = lres;
    else                    res_c = '0;
    cc_upd = ((is_arith || is_logic) && in_setcc) || (is_tag && !trap_c);
    cc_n.n = res_c[W-1];
    cc_n.z = (res_c == '0);
    if (is_logic) begin
      cc_n.v = 1'b0;
      cc_n.c = 1'b0;
    end else begin
      cc_n.v = v_fin;
      cc_n.c = c_out;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign cc       = cc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr     <= 1'b0;
      out_trap   <= 1'b0;
      cc_q       <= '0;
    end else begin
      if (acc) begin
        out_valid  <= 1'b1;
        out_result <= res_c;
        out_wr     <= wr_c;
        out_trap   <= trap_c;
        if (cc_upd) cc_q <= cc_n;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alu_tag_exec_chk.sv
module alu_tag_exec_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 13,
  parameter int HI_W  = 22,
  parameter int TAG_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [4:0]       in_op,
  input logic             in_setcc,
  input logic [W-1:0]     in_a,
  input logic [W-1:0]     in_b,
  input logic [IMM_W-1:0] in_imm,
  input logic             in_use_imm,
  input logic [HI_W-1:0]  in_hi,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_result,
  input logic             out_wr,
  input logic             out_trap,
  input logic [3:0]       cc
);
  localparam int LO_W = W - HI_W;

  logic acc, tag_hit;
  assign acc     = in_valid && in_ready;
  assign tag_hit = (|in_a[TAG_W-1:0]) |
                   (in_use_imm ? (|in_imm[TAG_W-1:0]) : (|in_b[TAG_W-1:0]));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_wr)
                                && $stable(out_trap) && $stable(cc));

  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r5_trap_nowr: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap |-> !out_wr);

  a_r5_trap_cc: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 5'd6 || in_op == 5'd7) && tag_hit |=> out_trap && $stable(cc));

  a_r8_shift_cc: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op >= 5'd14 && in_op <= 5'd17 |=> $stable(cc));

  a_r7_sethi_low: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 5'd17 |=> out_result[LO_W-1:0] == '0);

  a_r6_logic_vc: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_setcc && in_op >= 5'd8 && in_op <= 5'd13 |=> cc[1:0] == 2'b00);

  a_r11_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op > 5'd17 |=> !out_wr && !out_trap && $stable(cc));
endmodule

bind alu_tag_exec alu_tag_exec_chk #(
  .W(W), .IMM_W(IMM_W), .HI_W(HI_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/test_alu_tag_exec.sv
`timescale 1ns/1ps
module test_alu_tag_exec;
  import alu_tag_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic        in_setcc = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [12:0] in_imm = '0;
  logic        in_use_imm = 1'b0;
  logic [21:0] in_hi = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr;
  logic        out_trap;
  logic [3:0]  cc;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  alu_tag_exec i_alu_tag_exec (.*);

  typedef struct packed {
    logic [4:0]  op;
    logic        setcc;
    logic [31:0] a;
    logic [31:0] b;
    logic [12:0] imm;
    logic        ui;
    logic [21:0] hi;
    logic [31:0] e_res;
    logic        e_wr;
    logic [3:0]  e_cc;
    logic        e_trap;
    logic [31:0] tag;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  1'b1, 32'd5, 32'd3, 13'h0, 1'b0, 22'h0, 32'd8, 1'b1, 4'b0000, 1'b0, "R2  "},
    '{5'd0,  1'b1, 32'h7FFFFFFF, 32'h0, 13'h0001, 1'b1, 22'h0, 32'h80000000, 1'b1, 4'b1010, 1'b0, "R1  "},
    '{5'd0,  1'b1, 32'hFFFFFFFF, 32'd1, 13'h0, 1'b0, 22'h0, 32'h0, 1'b1, 4'b0101, 1'b0, "R2  "},
    '{5'd1,  1'b0, 32'd10, 32'd20, 13'h0, 1'b0, 22'h0, 32'd31, 1'b1, 4'b0101, 1'b0, "R3  "},
    '{5'd2,  1'b1, 32'd3, 32'd5, 13'h0, 1'b0, 22'h0, 32'hFFFFFFFE, 1'b1, 4'b1001, 1'b0, "R2  "},
    '{5'd3,  1'b1, 32'd10, 32'h0, 13'h1FFF, 1'b1, 22'h0, 32'd10, 1'b1, 4'b0001, 1'b0, "R3  "},
    '{5'd8,  1'b1, 32'hF0F0F0F0, 32'h0F0F0F0F, 13'h0, 1'b0, 22'h0, 32'h0, 1'b1, 4'b0100, 1'b0, "R6  "},
    '{5'd9,  1'b0, 32'hF0F0F0F0, 32'h00F000F0, 13'h0, 1'b0, 22'h0, 32'hF000F000, 1'b1, 4'b0100, 1'b0, "R10 "},
    '{5'd11, 1'b1, 32'h0, 32'hFFFF0000, 13'h0, 1'b0, 22'h0, 32'h0000FFFF, 1'b1, 4'b0000, 1'b0, "R6  "},
    '{5'd13, 1'b1, 32'h12345678, 32'h12345678, 13'h0, 1'b0, 22'h0, 32'hFFFFFFFF, 1'b1, 4'b1000, 1'b0, "R6  "},
    '{5'd14, 1'b1, 32'd1, 32'h0, 13'h0025, 1'b1, 22'h0, 32'd32, 1'b1, 4'b1000, 1'b0, "R8  "},
    '{5'd16, 1'b1, 32'h80000000, 32'd4, 13'h0, 1'b0, 22'h0, 32'hF8000000, 1'b1, 4'b1000, 1'b0, "R8  "},
    '{5'd15, 1'b1, 32'h80000000, 32'd31, 13'h0, 1'b0, 22'h0, 32'd1, 1'b1, 4'b1000, 1'b0, "R8  "},
    '{5'd17, 1'b1, 32'h12345678, 32'h0, 13'h0, 1'b0, 22'h3FFFFF, 32'hFFFFFC00, 1'b1, 4'b1000, 1'b0, "R7  "},
    '{5'd4,  1'b0, 32'd8, 32'd4, 13'h0, 1'b0, 22'h0, 32'd12, 1'b1, 4'b0000, 1'b0, "R10 "},
    '{5'd4,  1'b1, 32'd8, 32'd5, 13'h0, 1'b0, 22'h0, 32'd13, 1'b1, 4'b0010, 1'b0, "R4  "},
    '{5'd5,  1'b1, 32'd4, 32'd8, 13'h0, 1'b0, 22'h0, 32'hFFFFFFFC, 1'b1, 4'b1001, 1'b0, "R4  "},
    '{5'd6,  1'b1, 32'd8, 32'd6, 13'h0, 1'b0, 22'h0, 32'd14, 1'b0, 4'b1001, 1'b1, "R5  "},
    '{5'd7,  1'b1, 32'd12, 32'd4, 13'h0, 1'b0, 22'h0, 32'd8, 1'b1, 4'b0000, 1'b0, "R5  "},
    '{5'd4,  1'b1, 32'h7FFFFFFC, 32'd4, 13'h0, 1'b0, 22'h0, 32'h80000000, 1'b1, 4'b1010, 1'b0, "R4  "},
    '{5'd20, 1'b1, 32'd7, 32'd9, 13'h0, 1'b0, 22'h0, 32'h0, 1'b0, 4'b1010, 1'b0, "R11 "}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic sc, input logic [31:0] a,
                       input logic [31:0] b, input logic [12:0] imm, input logic ui,
                       input logic [21:0] hi);
    in_op = op; in_setcc = sc; in_a = a; in_b = b;
    in_imm = imm; in_use_imm = ui; in_hi = hi; in_valid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R12 reset state
    chk("R12", "out_valid", {31'b0, out_valid}, 32'd0);
    chk("R12", "in_ready", {31'b0, in_ready}, 32'd1);
    chk("R12", "cc", {28'b0, cc}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      string rq;
      @(negedge clk);
      drive(VECS[k].op, VECS[k].setcc, VECS[k].a, VECS[k].b, VECS[k].imm, VECS[k].ui, VECS[k].hi);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      rq = $sformatf("%s", VECS[k].tag);
      chk(rq, "out_valid", {31'b0, out_valid}, 32'd1);
      chk(rq, "result", out_result, VECS[k].e_res);
      chk(rq, "wr", {31'b0, out_wr}, {31'b0, VECS[k].e_wr});
      chk(rq, "cc", {28'b0, cc}, {28'b0, VECS[k].e_cc});
      chk(rq, "trap", {31'b0, out_trap}, {31'b0, VECS[k].e_trap});
    end

    // R9 back-pressure: hold result and flags, refuse new work
    @(negedge clk);
    out_ready = 1'b0;
    drive(5'd0, 1'b1, 32'd5, 32'd6, 13'h0, 1'b0, 22'h0);
    @(posedge clk);
    @(negedge clk);
    drive(5'd2, 1'b1, 32'd0, 32'd1, 13'h0, 1'b0, 22'h0);
    for (int s = 0; s < 3; s++) begin
      chk("R9", "stall in_ready", {31'b0, in_ready}, 32'd0);
      chk("R9", "stall result", out_result, 32'd11);
      chk("R9", "stall cc", {28'b0, cc}, 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "release result", out_result, 32'hFFFFFFFF);
    chk("R9", "release cc", {28'b0, cc}, 32'b1001);
    @(posedge clk);
    @(negedge clk);
    chk("R9", "drain out_valid", {31'b0, out_valid}, 32'd0);

    // R12 reset clears flags again
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R12", "cc after reset", {28'b0, cc}, 32'd0);
    chk("R12", "out_valid after reset", {31'b0, out_valid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule